// File: doc/BRIEF.md
# Hybrid Branch Direction Predictor

This block guesses whether a branch at a given fetch address will be taken. It is consulted at fetch, once the target lookup has found a branch at that address. Two component predictors run side by side. The first is a per-address table of 2-bit saturating counters. The second is a table of the same counters whose index is the address bits XOR a global record of recent outcomes. A third table of 2-bit counters, indexed by address alone, learns which of the two components to trust for each branch, and its upper bit selects the prediction that is driven out.

The predict side is combinational. It takes a fetch address and returns the taken/not-taken guess and the current global history. The fetch pipeline keeps that history value with the branch. When the branch resolves, the pipeline presents the address, the real outcome and the saved history on the update side. On that clock edge both components are trained, the chooser is adjusted, and the outcome is shifted into the history. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `hyb_dir_pred`

## Requirements
- R1: After reset every counter is weak not-taken (01), every chooser is weak bimodal (01) and the history is zero, so `pred_taken` is 0 for any address and `pred_hist` is 0.
- R2: Each accepted update shifts the outcome into the history at bit 0, so the new `pred_hist` is {old[6:0], outcome}.
- R3: Counters are 2-bit and use the encoding 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. The prediction is the upper bit. A taken outcome adds one and a not-taken outcome subtracts one, so from a strong state it takes two opposite outcomes to flip the prediction.
- R4: Counters saturate at 00 and 11 and never wrap.
- R5: The per-address table and the chooser use address bits 9:2 as the index. Addresses that differ only in bits 1:0 or above bit 9 share an entry.
- R6: The correlated table is indexed by address bits 9:2 XOR the history. A chooser upper bit of 1 selects the correlated prediction and 0 selects the per-address prediction.
- R7: The chooser steps toward correlated (+1) only when the components disagree and the correlated one was right. It steps toward per-address (-1) in the mirror case. It does not change when both were right or both were wrong.
- R8: Both components train on every update, whichever one was chosen. The correlated entry trained is the one at address bits XOR `upd_hist`.
- R9: When a predict and an update fall in the same cycle, the prediction and `pred_hist` reflect the state before that update. The update becomes visible from the next cycle.
- R10: When `upd_valid` is low, the tables and the history do not change, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pred_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_hist | output | 8 | Global history at predict time, to be returned on update |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Actual outcome |
| upd_hist | input | 8 | History value captured when the branch was predicted |

## Verification
A lookup and a training write can land on the same counter entry in the same cycle. The bench provokes this by presenting one fresh address on both sides in one cycle. It judges the result by sampling the guess and the history before the edge, where the old not-taken value and the old history must appear, and again after the edge, where the trained taken value and the shifted history must appear. The chooser is steered by building deliberate disagreements between the two components. The bench then sets the history through training on an unrelated address so that the two components point in opposite directions, and reads which direction comes out.

// File: rtl/hyb_pkg.sv
package hyb_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_SNT = 2'b00;
  localparam ctr2_t CTR_WNT = 2'b01;
  localparam ctr2_t CTR_WT  = 2'b10;
  localparam ctr2_t CTR_ST  = 2'b11;

  // saturating step of a 2-bit counter
  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic inc);
    ctr2_t res;
    if (inc) res = (cur == CTR_ST) ? CTR_ST : cur + 2'd1;
    else     res = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
    return res;
  endfunction
endpackage

// File: rtl/hyb_ctr_table.sv
module hyb_ctr_table
  import hyb_pkg::*;
#(
  parameter int    IDX_W   = 8,
  parameter ctr2_t RST_VAL = CTR_WNT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_val,
  input  logic [IDX_W-1:0] up_idx,
  input  logic             up_en,
  input  logic             up_inc,
  output ctr2_t            up_old
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];
  ctr2_t nxt_val;

  assign rd_val = mem[rd_idx];
  assign up_old = mem[up_idx];

  always_comb begin
    nxt_val = ctr_step(up_old, up_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= RST_VAL;
    end else if (up_en) begin
      mem[up_idx] <= nxt_val;
    end
  end

  // R3: a written counter moves by exactly one step
  assert_ctr_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_inc && up_old != CTR_ST) |=> mem[$past(up_idx)] == $past(up_old) + 2'd1);
  assert_ctr_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !up_inc && up_old != CTR_SNT) |=> mem[$past(up_idx)] == $past(up_old) - 2'd1);
  // R4: saturation at both ends
  assert_ctr_ceiling_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_inc && up_old == CTR_ST) |=> mem[$past(up_idx)] == CTR_ST);
  assert_ctr_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !up_inc && up_old == CTR_SNT) |=> mem[$past(up_idx)] == CTR_SNT);
endmodule

// File: rtl/hyb_ghr.sv
module hyb_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_nxt;

  always_comb begin
    hist_nxt = hist;
    if (shift_en) hist_nxt = {hist[HIST_W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist <= '0;
    else        hist <= hist_nxt;
  end

  // R2: newest outcome lands in bit 0
  assert_hist_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (hist[0] == $past(bit_in)) && (hist[HIST_W-1:1] == $past(hist[HIST_W-2:0])));
  // R10: no strobe, no change
  assert_hist_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist));
endmodule

// File: rtl/hyb_dir_pred.sv
module hyb_dir_pred
  import hyb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PC_W-1:0]  pred_pc,
  output logic             pred_taken,
  output logic [IDX_W-1:0] pred_hist,
  input  logic             upd_valid,
  input  logic [PC_W-1:0]  upd_pc,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] upd_hist
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic [IDX_W-1:0] ghr;
  logic [IDX_W-1:0] p_idx, p_cidx, u_idx, u_cidx;
  ctr2_t p_bim, p_cor, p_cho;
  ctr2_t u_bim, u_cor, u_cho;
  logic  bim_ok, cor_ok, cho_en;

  assign p_idx  = pred_pc[IDX_HI:IDX_LO];
  assign p_cidx = p_idx ^ ghr;
  assign u_idx  = upd_pc[IDX_HI:IDX_LO];
  assign u_cidx = u_idx ^ upd_hist;

  always_comb begin
    bim_ok = (u_bim[1] == upd_taken);
    cor_ok = (u_cor[1] == upd_taken);
    cho_en = upd_valid && (bim_ok != cor_ok);
  end

  always_comb begin
    pred_taken = p_cho[1] ? p_cor[1] : p_bim[1];
    pred_hist  = ghr;
  end

  hyb_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_bim_tab (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(p_idx), .rd_val(p_bim),
    .up_idx(u_idx), .up_en(upd_valid), .up_inc(upd_taken), .up_old(u_bim)
  );

  hyb_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_cor_tab (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(p_cidx), .rd_val(p_cor),
    .up_idx(u_cidx), .up_en(upd_valid), .up_inc(upd_taken), .up_old(u_cor)
  );

  // chooser: upper bit set means use the correlated component
  hyb_ctr_table #(.IDX_W(IDX_W), .RST_VAL(CTR_WNT)) u_cho_tab (
    .clk(clk), .rst_n(rst_int_n),
    .rd_idx(p_idx), .rd_val(p_cho),
    .up_idx(u_idx), .up_en(cho_en), .up_inc(cor_ok), .up_old(u_cho)
  );

  hyb_ghr #(.HIST_W(IDX_W)) u_ghr (
    .clk(clk), .rst_n(rst_int_n),
    .shift_en(upd_valid), .bit_in(upd_taken), .hist(ghr)
  );

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pred_pc[PC_W-1:IDX_HI+1], pred_pc[IDX_LO-1:0],
                            upd_pc[PC_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0], p_cho[0], u_cho};

  // R1: history is zero on the first cycle out of reset
  assert_hist_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pipe == 2'b01) |=> (pred_hist == '0));
  // R6: the driven guess always matches one of the two components
  assert_pick_source_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (p_bim[1] == p_cor[1]) |-> (pred_taken == p_bim[1]));
endmodule

// File: tb/hyb_dir_pred_test.sv
`timescale 1ns/1ps
module hyb_dir_pred_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pred_pc;
  logic        pred_taken;
  logic [7:0]  pred_hist;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic        upd_taken;
  logic [7:0]  upd_hist;

  int   n_chk  = 0;
  int   n_fail = 0;
  logic [7:0] exp_hist = 8'h00;
  localparam logic [31:0] SCRATCH = 32'h0000_03C0;

  always #2.5 clk = ~clk;

  hyb_dir_pred uut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] pc, input logic exp, input string req);
    pred_pc = pc;
    #1;
    chk(pred_taken == exp, req, int'(pred_taken), int'(exp));
  endtask

  task automatic upd(input logic [31:0] pc, input logic [7:0] h, input logic t);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_hist = h; upd_taken = t;
    @(negedge clk);
    upd_valid = 1'b0;
    exp_hist = {exp_hist[6:0], t};
  endtask

  task automatic set_ghr(input logic [7:0] v);
    for (int b = 7; b >= 0; b--) upd(SCRATCH, 8'h00, v[b]);
  endtask

  task automatic t_reset;
    look(32'h0000_0040, 1'b0, "R1");
    look(32'h0000_0abc, 1'b0, "R1");
    look(32'hffff_fffc, 1'b0, "R1");
    chk(pred_hist == 8'h00, "R1", int'(pred_hist), 0);
  endtask

  task automatic t_history;
    upd(SCRATCH, 8'h00, 1'b1);
    chk(pred_hist == 8'h01, "R2", int'(pred_hist), 1);
    upd(SCRATCH, 8'h00, 1'b0);
    chk(pred_hist == 8'h02, "R2", int'(pred_hist), 2);
    upd(SCRATCH, 8'h00, 1'b1);
    chk(pred_hist == 8'h05, "R2", int'(pred_hist), 5);
    set_ghr(8'hA6);
    chk(pred_hist == 8'hA6, "R2", int'(pred_hist), 166);
    set_ghr(8'h00);
  endtask

  task automatic t_saturate;
    upd(32'h100, 8'h00, 1'b1);
    look(32'h100, 1'b1, "R3 one taken from weak NT");
    repeat (3) upd(32'h100, 8'h00, 1'b1);
    upd(32'h100, 8'h00, 1'b0);
    look(32'h100, 1'b1, "R4 ceiling held after one NT");
    upd(32'h100, 8'h00, 1'b0);
    look(32'h100, 1'b0, "R3 second NT flips");
    repeat (3) upd(32'h100, 8'h00, 1'b0);
    upd(32'h100, 8'h00, 1'b1);
    look(32'h100, 1'b0, "R4 floor held after one taken");
  endtask

  task automatic t_alias;
    upd(32'h503, 8'h00, 1'b1);
    look(32'h100, 1'b1, "R5 shared entry");
    look(32'h101, 1'b1, "R5 low bits ignored");
    look(32'h104, 1'b0, "R5 neighbour untouched");
  endtask

  task automatic t_chooser;
    upd(32'h7C, 8'h00, 1'b1);
    upd(32'h7C, 8'h00, 1'b1);
    look(32'h40, 1'b0, "R6 bimodal chosen by default");
    upd(32'h40, 8'h0F, 1'b1);
    set_ghr(8'h00);
    look(32'h40, 1'b0, "R7 chooser moved to correlated");
    set_ghr(8'h0F);
    look(32'h40, 1'b1, "R8 correlated entry trained by other PC");
    upd(32'h40, 8'h0F, 1'b1);
    upd(32'h40, 8'h20, 1'b1);
    set_ghr(8'h00);
    look(32'h40, 1'b1, "R7 chooser back to bimodal");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    pred_pc = 32'h200;
    upd_valid = 1'b1; upd_pc = 32'h200; upd_hist = 8'h00; upd_taken = 1'b1;
    #1;
    chk(pred_taken == 1'b0, "R9 old value before edge", int'(pred_taken), 0);
    chk(pred_hist == exp_hist, "R9 old history before edge", int'(pred_hist), int'(exp_hist));
    @(negedge clk);
    upd_valid = 1'b0;
    exp_hist = {exp_hist[6:0], 1'b1};
    #1;
    chk(pred_taken == 1'b1, "R9 new value after edge", int'(pred_taken), 1);
    chk(pred_hist == exp_hist, "R9 history after edge", int'(pred_hist), int'(exp_hist));
    upd_pc = 32'h200; upd_taken = 1'b0; upd_hist = 8'hFF;
    repeat (2) @(negedge clk);
    #1;
    chk(pred_taken == 1'b1, "R10 table unchanged", int'(pred_taken), 1);
    chk(pred_hist == exp_hist, "R10 history unchanged", int'(pred_hist), int'(exp_hist));
  endtask

  initial begin
    rst_n = 1'b0; pred_pc = '0; upd_valid = 1'b0; upd_pc = '0;
    upd_taken = 1'b0; upd_hist = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_history;
    t_saturate;
    t_alias;
    t_chooser;
    t_same_cycle;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule